// File: doc/BRIEF.md
# DAC Load and Busy Sequencer

This block decides when the per-channel input registers of a multi-channel DAC are copied into the registers that drive the converter outputs. It also drives an active-low busy flag while the device is working. Busy goes low in three cases: a calculation that follows a write to an input register, a clear sequence that forces every output to a programmable code, and a digital reset sequence that restores every register set to its power-on value. The calculation itself is not modelled and takes a fixed number of cycles. The clear and reset sequences last for parameters derived from the clock frequency, 35 us and 270 us by default.

The host writes the input, gain, offset and clear-code registers through a simple write port and reads them back through a combinational read port. Three control pins act on the block. A load strobe (active low) transfers the input registers to the outputs on its falling edge. A clear pin starts the clear sequence on its falling edge. A reset pin starts the reset sequence on its falling edge. A load that arrives while busy is low for a calculation or a clear is held as one pending transfer, and that transfer is applied on the cycle busy returns high. A load that arrives during a reset is dropped. A reset edge overrides any sequence in progress.

Top module: `dac_load_seq`

## Requirements
- R1: After the system reset input is released, busy stays low for exactly RST_CYCLES clock cycles. Every input register reads 0, every gain register reads all ones, every offset register reads 2^(DATA_W-1), the clear code reads 0 and every DAC output is 0.
- R2: A write with wrSel 0 (input), 1 (gain), 2 (offset) or 3 (clear code, channel ignored) stores wrData, and the stored value is returned on rdData for the same rdSel/rdCh encoding.
- R3: A write to an input register while busy is high drives busy low for exactly CALC_CYCLES cycles. Writes to gain, offset or clear code leave busy high.
- R4: A falling edge on loadN while busy is high copies every input register to its DAC output on the next clock edge, and busy stays high. The DAC outputs do not change without such an event.
- R5: A falling edge on loadN during a calculation leaves the outputs unchanged and does not extend busy. The transfer takes place on the edge where busy returns high.
- R6: Any number of load edges during one busy period produce a single transfer. A later calculation with no load edge leaves the outputs unchanged.
- R7: A falling edge on clrN while not in reset sets every DAC output to the clear code on the next edge and holds busy low for exactly CLR_CYCLES cycles. A load edge during the clear is applied when busy returns high.
- R8: A falling edge on rstN restores all registers to the R1 values and holds busy low for exactly RST_CYCLES cycles. It aborts a calculation or clear in progress and discards a pending load.
- R9: During a reset sequence, register writes, load edges and clear edges have no effect, and they do not lengthen busy.
- R10: Holding rstN low after a reset sequence completes does not start another one. Only a new falling edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sysRstN | input | 1 | Asynchronous power-on reset, active low |
| wrEn | input | 1 | Register write enable |
| wrSel | input | 2 | Write target: 0 input, 1 gain, 2 offset, 3 clear code |
| wrCh | input | CH_W | Write channel |
| wrData | input | DATA_W | Write data |
| rdSel | input | 2 | Read target, same encoding as wrSel |
| rdCh | input | CH_W | Read channel |
| rdData | output | DATA_W | Combinational read data |
| loadN | input | 1 | Load strobe, acts on falling edge |
| clrN | input | 1 | Clear request, acts on falling edge |
| rstN | input | 1 | Digital reset request, acts on falling edge |
| busyN | output | 1 | Low while a calculation, clear or reset runs |
| dacOut | output | NUM_CH*DATA_W | DAC register contents, channel 0 in the low bits |

## Verification
The main function is exercised with several data patterns swept over every channel. Comparing outputs before and after a load shows whether the transfer is strobe-driven or leaks through on writes. Load edges are placed at three points: while idle, inside a calculation and inside a clear. These tell an immediate transfer apart from a deferred one, and a single transfer from a repeated one. Reset edges are placed during a calculation with a load pending, during a clear, and while writes, loads and clears are also being issued. Checking the register contents and the busy length afterwards separates discarded events from honoured ones. A reset pin that stays low shows whether the sequence responds to the level or only to the edge.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CALC  = 2'd1,
    ST_CLEAR = 2'd2,
    ST_RESET = 2'd3
  } seqState_t;

  typedef enum logic [1:0] {
    SEL_INPUT  = 2'd0,
    SEL_GAIN   = 2'd1,
    SEL_OFFSET = 2'd2,
    SEL_CODE   = 2'd3
  } regSel_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic loadDac;      // copy input registers to DAC registers
    logic clearDac;     // copy clear code to every DAC register
    logic setDefaults;  // restore power-on values
    logic wrAllow;      // host writes may land this cycle
  } seqStrobe_t;

endpackage

// File: rtl/dac_seq_edge.sv
module dac_seq_edge (
  input  logic clk,
  input  logic arstN,
  input  logic lvl,
  output logic fall
);

  logic prevLvl;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) prevLvl <= 1'b1;
    else        prevLvl <= lvl;
  end

  assign fall = prevLvl & ~lvl;

endmodule

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
  import dac_seq_pkg::*;
#(
  parameter int CALC_CYCLES = 16,
  parameter int CLR_CYCLES  = 3500,
  parameter int RST_CYCLES  = 27000
) (
  input  logic       clk,
  input  logic       sysRstN,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic       loadN,
  input  logic       clrN,
  input  logic       rstN,
  output logic       busyN,
  output seqStrobe_t strobe
);

  localparam int MAX_AB  = (CALC_CYCLES > CLR_CYCLES) ? CALC_CYCLES : CLR_CYCLES;
  localparam int MAX_CYC = (MAX_AB > RST_CYCLES) ? MAX_AB : RST_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] CALC_LAST = CNT_W'(CALC_CYCLES - 1);
  localparam logic [CNT_W-1:0] CLR_LAST  = CNT_W'(CLR_CYCLES - 1);
  localparam logic [CNT_W-1:0] RST_LAST  = CNT_W'(RST_CYCLES - 1);
  localparam int IDX_LOAD = 0;
  localparam int IDX_CLR  = 1;
  localparam int IDX_RST  = 2;
  localparam int N_EDGE   = 3;

  logic [N_EDGE-1:0] pinLvl;
  logic [N_EDGE-1:0] fallVec;

  assign pinLvl = {rstN, clrN, loadN};

  for (genvar i = 0; i < N_EDGE; i++) begin : g_edge
    dac_seq_edge i_edge (
      .clk  (clk),
      .arstN(sysRstN),
      .lvl  (pinLvl[i]),
      .fall (fallVec[i])
    );
  end

  seqState_t        state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             pending, nextPend;
  logic             pendOr;
  logic             inputWr;

  assign pendOr  = pending | fallVec[IDX_LOAD];
  assign inputWr = wrEn && (regSel_t'(wrSel) == SEL_INPUT);

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    nextPend  = pending;
    strobe    = '0;
    unique case (state)
      ST_RESET: begin
        if (cnt == '0) nextState = ST_IDLE;
        else           nextCnt   = cnt - CNT_W'(1);
      end
      default: begin
        strobe.wrAllow = !fallVec[IDX_RST];
        if (fallVec[IDX_RST]) begin
          nextState          = ST_RESET;
          nextCnt            = RST_LAST;
          nextPend           = 1'b0;
          strobe.setDefaults = 1'b1;
        end else if (fallVec[IDX_CLR] && state != ST_CLEAR) begin
          nextState       = ST_CLEAR;
          nextCnt         = CLR_LAST;
          nextPend        = pendOr;
          strobe.clearDac = 1'b1;
        end else if (state == ST_IDLE) begin
          strobe.loadDac = fallVec[IDX_LOAD];
          if (inputWr) begin
            nextState = ST_CALC;
            nextCnt   = CALC_LAST;
          end
        end else if (state == ST_CALC && inputWr) begin
          nextCnt  = CALC_LAST;
          nextPend = pendOr;
        end else if (cnt == '0) begin
          nextState      = ST_IDLE;
          nextPend       = 1'b0;
          strobe.loadDac = pendOr;
        end else begin
          nextCnt  = cnt - CNT_W'(1);
          nextPend = pendOr;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      state   <= ST_RESET;
      cnt     <= RST_LAST;
      pending <= 1'b0;
    end else begin
      state   <= nextState;
      cnt     <= nextCnt;
      pending <= nextPend;
    end
  end

  assign busyN = (state == ST_IDLE);

endmodule

// File: rtl/dac_seq_datapath.sv
module dac_seq_datapath
  import dac_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 12,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     sysRstN,
  input  seqStrobe_t               strobe,
  input  logic                     wrEn,
  input  logic [1:0]               wrSel,
  input  logic [CH_W-1:0]          wrCh,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [1:0]               rdSel,
  input  logic [CH_W-1:0]          rdCh,
  output logic [DATA_W-1:0]        rdData,
  output logic [NUM_CH*DATA_W-1:0] dacOut
);

  localparam logic [DATA_W-1:0] INPUT_DEF  = '0;
  localparam logic [DATA_W-1:0] GAIN_DEF   = '1;
  localparam logic [DATA_W-1:0] OFFSET_DEF = DATA_W'(1) << (DATA_W - 1);
  localparam logic [DATA_W-1:0] CODE_DEF   = '0;
  localparam logic [DATA_W-1:0] DAC_DEF    = '0;

  logic [DATA_W-1:0] inReg   [NUM_CH];
  logic [DATA_W-1:0] gainReg [NUM_CH];
  logic [DATA_W-1:0] offReg  [NUM_CH];
  logic [DATA_W-1:0] dacReg  [NUM_CH];
  logic [DATA_W-1:0] codeReg;
  logic              wrOk;

  assign wrOk = wrEn && strobe.wrAllow;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = wrOk && (wrCh == CH_W'(c));

    always_ff @(posedge clk or negedge sysRstN) begin
      if (!sysRstN) begin
        inReg[c]   <= INPUT_DEF;
        gainReg[c] <= GAIN_DEF;
        offReg[c]  <= OFFSET_DEF;
        dacReg[c]  <= DAC_DEF;
      end else if (strobe.setDefaults) begin
        inReg[c]   <= INPUT_DEF;
        gainReg[c] <= GAIN_DEF;
        offReg[c]  <= OFFSET_DEF;
        dacReg[c]  <= DAC_DEF;
      end else begin
        if (hit && regSel_t'(wrSel) == SEL_INPUT)  inReg[c]   <= wrData;
        if (hit && regSel_t'(wrSel) == SEL_GAIN)   gainReg[c] <= wrData;
        if (hit && regSel_t'(wrSel) == SEL_OFFSET) offReg[c]  <= wrData;
        if (strobe.clearDac)     dacReg[c] <= codeReg;
        else if (strobe.loadDac) dacReg[c] <= inReg[c];
      end
    end

    assign dacOut[c*DATA_W +: DATA_W] = dacReg[c];
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)                                          codeReg <= CODE_DEF;
    else if (strobe.setDefaults)                           codeReg <= CODE_DEF;
    else if (wrOk && regSel_t'(wrSel) == SEL_CODE)         codeReg <= wrData;
  end

  always_comb begin
    rdData = '0;
    if (regSel_t'(rdSel) == SEL_CODE) begin
      rdData = codeReg;
    end else if (int'(rdCh) < NUM_CH) begin
      unique case (regSel_t'(rdSel))
        SEL_INPUT:  rdData = inReg[rdCh];
        SEL_GAIN:   rdData = gainReg[rdCh];
        SEL_OFFSET: rdData = offReg[rdCh];
        default:    rdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/dac_load_seq.sv
module dac_load_seq
  import dac_seq_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int DATA_W      = 12,
  parameter int CLK_MHZ     = 100,
  parameter int CALC_CYCLES = 16,
  parameter int CLR_CYCLES  = CLK_MHZ * 35,
  parameter int RST_CYCLES  = CLK_MHZ * 270,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     sysRstN,
  input  logic                     wrEn,
  input  logic [1:0]               wrSel,
  input  logic [CH_W-1:0]          wrCh,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [1:0]               rdSel,
  input  logic [CH_W-1:0]          rdCh,
  output logic [DATA_W-1:0]        rdData,
  input  logic                     loadN,
  input  logic                     clrN,
  input  logic                     rstN,
  output logic                     busyN,
  output logic [NUM_CH*DATA_W-1:0] dacOut
);

  seqStrobe_t seqStrobe;

  dac_seq_ctrl #(
    .CALC_CYCLES(CALC_CYCLES),
    .CLR_CYCLES (CLR_CYCLES),
    .RST_CYCLES (RST_CYCLES)
  ) i_ctrl (
    .clk    (clk),
    .sysRstN(sysRstN),
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .loadN  (loadN),
    .clrN   (clrN),
    .rstN   (rstN),
    .busyN  (busyN),
    .strobe (seqStrobe)
  );

  dac_seq_datapath #(
    .NUM_CH(NUM_CH),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk    (clk),
    .sysRstN(sysRstN),
    .strobe (seqStrobe),
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrCh   (wrCh),
    .wrData (wrData),
    .rdSel  (rdSel),
    .rdCh   (rdCh),
    .rdData (rdData),
    .dacOut (dacOut)
  );

endmodule

// File: rtl/dac_load_seq_chk.sv
module dac_load_seq_chk #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 12
) (
  input logic                     clk,
  input logic                     sysRstN,
  input logic                     wrEn,
  input logic [1:0]               wrSel,
  input logic                     loadN,
  input logic                     clrN,
  input logic                     rstN,
  input logic                     busyN,
  input logic [NUM_CH*DATA_W-1:0] dacOut
);

  AST_POWERON_BUSY: assert property (@(posedge clk) disable iff (!sysRstN)
    $rose(sysRstN) |-> !busyN); // R1

  AST_INPUT_WRITE_BUSY: assert property (@(posedge clk) disable iff (!sysRstN)
    busyN && wrEn && wrSel == 2'd0 |=> !busyN); // R3

  AST_OTHER_WRITE_IDLE: assert property (@(posedge clk) disable iff (!sysRstN)
    busyN && wrEn && wrSel != 2'd0 && !$fell(clrN) && !$fell(rstN) |=> busyN); // R3

  AST_IDLE_LOAD_IDLE: assert property (@(posedge clk) disable iff (!sysRstN)
    busyN && $fell(loadN) && !$fell(clrN) && !$fell(rstN)
      && !(wrEn && wrSel == 2'd0) |=> busyN); // R4

  AST_DAC_CHANGE_CAUSE: assert property (@(posedge clk) disable iff (!sysRstN)
    !$stable(dacOut) |-> busyN || $past(busyN)
      || ($past(clrN, 2) && !$past(clrN))
      || ($past(rstN, 2) && !$past(rstN))); // R5

  AST_CLEAR_BUSY: assert property (@(posedge clk) disable iff (!sysRstN)
    busyN && $fell(clrN) |=> !busyN); // R7

  AST_RESET_BUSY: assert property (@(posedge clk) disable iff (!sysRstN)
    busyN && $fell(rstN) |=> !busyN); // R8

  AST_HELD_RESET_QUIET: assert property (@(posedge clk) disable iff (!sysRstN)
    busyN && !rstN && !$fell(rstN) && !$fell(clrN)
      && !(wrEn && wrSel == 2'd0) |=> busyN); // R10

endmodule

bind dac_load_seq dac_load_seq_chk #(
  .NUM_CH(NUM_CH),
  .DATA_W(DATA_W)
) i_chk (
  .clk    (clk),
  .sysRstN(sysRstN),
  .wrEn   (wrEn),
  .wrSel  (wrSel),
  .loadN  (loadN),
  .clrN   (clrN),
  .rstN   (rstN),
  .busyN  (busyN),
  .dacOut (dacOut)
);

// File: tb/test_dac_load_seq.sv
module test_dac_load_seq;

  localparam int NUM_CH = 4;
  localparam int DATA_W = 8;
  localparam int CALC   = 9;
  localparam int CLR    = 7;
  localparam int RST    = 11;
  localparam int CH_W   = 2;

  logic clk = 1'b0;
  logic sysRstN, wrEn, loadN, clrN, rstN;
  logic [1:0] wrSel, rdSel;
  logic [CH_W-1:0] wrCh, rdCh;
  logic [DATA_W-1:0] wrData, rdData;
  logic busyN;
  logic [NUM_CH*DATA_W-1:0] dacOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] expIn[NUM_CH], expGain[NUM_CH], expOff[NUM_CH], expDac[NUM_CH];
  logic [DATA_W-1:0] expCode;

  always #2 clk = ~clk;

  dac_load_seq #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .CLK_MHZ(1),
    .CALC_CYCLES(CALC), .CLR_CYCLES(CLR), .RST_CYCLES(RST)
  ) i_dac_load_seq (
    .clk(clk), .sysRstN(sysRstN), .wrEn(wrEn), .wrSel(wrSel), .wrCh(wrCh),
    .wrData(wrData), .rdSel(rdSel), .rdCh(rdCh), .rdData(rdData),
    .loadN(loadN), .clrN(clrN), .rstN(rstN), .busyN(busyN), .dacOut(dacOut)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic setDefaults();
    for (int c = 0; c < NUM_CH; c++) begin
      expIn[c] = '0; expGain[c] = '1; expOff[c] = 8'h80; expDac[c] = '0;
    end
    expCode = '0;
  endtask

  task automatic checkRegs(input string req);
    logic [DATA_W-1:0] e;
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < NUM_CH; c++) begin
        rdSel = 2'(s); rdCh = CH_W'(c); #1;
        case (s)
          0: e = expIn[c];
          1: e = expGain[c];
          2: e = expOff[c];
          default: e = expCode;
        endcase
        chk(req, $sformatf("read sel %0d ch %0d", s, c), int'(rdData), int'(e));
      end
  endtask

  task automatic checkDac(input string req);
    for (int c = 0; c < NUM_CH; c++)
      chk(req, $sformatf("dac ch %0d", c), int'(dacOut[c*DATA_W +: DATA_W]), int'(expDac[c]));
  endtask

  task automatic writeReg(input int sel, input int ch, input logic [DATA_W-1:0] d);
    wrEn = 1'b1; wrSel = 2'(sel); wrCh = CH_W'(ch); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseLoad();
    loadN = 1'b0; @(negedge clk);
    loadN = 1'b1; @(negedge clk);
  endtask

  task automatic pulseClr();
    clrN = 1'b0; @(negedge clk);
    clrN = 1'b1; @(negedge clk);
  endtask

  task automatic measureBusy(output int n);
    n = 0;
    while (busyN === 1'b0 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int c, input int p);
    return DATA_W'((c * 37 + p * 91 + 5) % 256);
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    sysRstN = 1'b0; wrEn = 1'b0; wrSel = '0; wrCh = '0; wrData = '0;
    rdSel = '0; rdCh = '0; loadN = 1'b1; clrN = 1'b1; rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1: power-on sequence and defaults
    sysRstN = 1'b1;
    measureBusy(n);
    chk("R1", "power-on busy length", n, RST);
    setDefaults();
    checkRegs("R1");
    checkDac("R1");

    // R2 R3 R4: sweep of patterns over all channels
    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < NUM_CH; c++) begin
        writeReg(0, c, pat(c, p));
        expIn[c] = pat(c, p);
        measureBusy(n);
        chk("R3", "input write busy length", n, CALC);
        writeReg(1, c, pat(c, p) ^ 8'h5A);
        expGain[c] = pat(c, p) ^ 8'h5A;
        chk("R3", "gain write keeps busy high", int'(busyN), 1);
        writeReg(2, c, pat(c, p) ^ 8'hC3);
        expOff[c] = pat(c, p) ^ 8'hC3;
        chk("R3", "offset write keeps busy high", int'(busyN), 1);
      end
      writeReg(3, 0, pat(p, p + 1));
      expCode = pat(p, p + 1);
      chk("R3", "code write keeps busy high", int'(busyN), 1);
      checkRegs("R2");
      checkDac("R4");
      pulseLoad();
      chk("R4", "busy after idle load", int'(busyN), 1);
      for (int c = 0; c < NUM_CH; c++) expDac[c] = expIn[c];
      checkDac("R4");
    end

    // R5: load during calculation deferred
    writeReg(0, 0, 8'hA5); expIn[0] = 8'hA5;
    pulseLoad();
    chk("R5", "busy low during calc", int'(busyN), 0);
    checkDac("R5");
    measureBusy(n);
    chk("R5", "calc length unchanged by load", n, CALC - 2);
    for (int c = 0; c < NUM_CH; c++) expDac[c] = expIn[c];
    checkDac("R5");

    // R6: multiple loads collapse into one transfer
    writeReg(0, 1, 8'h3C); expIn[1] = 8'h3C;
    pulseLoad();
    pulseLoad();
    measureBusy(n);
    chk("R6", "calc length with two loads", n, CALC - 4);
    for (int c = 0; c < NUM_CH; c++) expDac[c] = expIn[c];
    checkDac("R6");
    writeReg(0, 2, 8'h69); expIn[2] = 8'h69;
    measureBusy(n);
    chk("R6", "calc length without load", n, CALC);
    checkDac("R6");

    // R7: clear then clear with a load inside
    writeReg(3, 0, 8'hE7); expCode = 8'hE7;
    clrN = 1'b0; @(negedge clk);
    for (int c = 0; c < NUM_CH; c++) expDac[c] = expCode;
    checkDac("R7");
    measureBusy(n);
    chk("R7", "clear busy length", n, CLR);
    clrN = 1'b1; @(negedge clk);
    pulseClr();
    pulseLoad();
    checkDac("R7");
    measureBusy(n);
    chk("R7", "clear length with load", n, CLR - 3);
    for (int c = 0; c < NUM_CH; c++) expDac[c] = expIn[c];
    checkDac("R7");

    // R8: reset aborts calculation and drops pending load
    writeReg(0, 3, 8'h11); expIn[3] = 8'h11;
    pulseLoad();
    rstN = 1'b0; @(negedge clk);
    measureBusy(n);
    chk("R8", "reset busy length in calc", n, RST);
    setDefaults();
    checkRegs("R8");
    checkDac("R8");
    writeReg(0, 0, 8'h33); expIn[0] = 8'h33;
    measureBusy(n);
    chk("R8", "calc length after reset", n, CALC);
    checkDac("R8");

    // R10: held low level does not retrigger
    repeat (10) @(negedge clk);
    chk("R10", "busy with rstN held low", int'(busyN), 1);
    rstN = 1'b1; @(negedge clk);

    // R8: reset aborts a clear
    writeReg(1, 2, 8'h42); expGain[2] = 8'h42;
    pulseClr();
    rstN = 1'b0; @(negedge clk);
    measureBusy(n);
    chk("R8", "reset busy length in clear", n, RST);
    setDefaults();
    checkRegs("R8");
    checkDac("R8");
    rstN = 1'b1; @(negedge clk);

    // R9: activity during reset ignored
    rstN = 1'b0; @(negedge clk);
    writeReg(1, 1, 8'h12);
    writeReg(0, 0, 8'h77);
    pulseLoad();
    pulseClr();
    measureBusy(n);
    chk("R9", "reset length with activity", n, RST - 6);
    checkRegs("R9");
    checkDac("R9");

    // R10: new falling edge retriggers
    repeat (5) @(negedge clk);
    chk("R10", "busy after held low", int'(busyN), 1);
    rstN = 1'b1; repeat (2) @(negedge clk);
    rstN = 1'b0; @(negedge clk);
    measureBusy(n);
    chk("R10", "reset on new edge", n, RST);
    rstN = 1'b1; @(negedge clk);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule